// File: doc/BRIEF.md
# Key-Protected Watchdog Interval Timer

This block is an 8-bit up-counter that serves as an interval timer. It is clocked through a selectable prescaler that runs from a peripheral-clock enable. Software reaches it through one 16-bit write port. The upper byte of each write is a key. One key value loads the control/status byte and restarts the prescaler. A second key value loads the counter. Any other key is dropped.

The control/status byte holds three things: the run enable, a three-bit clock select and a sticky overflow flag. When the counter wraps from 0xFF to 0x00 it sets the flag and emits a one-cycle interrupt request. Alongside the request it presents a priority level and a vector, both taken from two byte-wide register inputs at the moment of overflow. A one-bit read select returns either the control/status byte or the counter.

Top module: `wdog_interval_timer`

## Requirements
- R1: After reset the control/status byte and the counter both read 0x00, the request is low, and level and vector are zero.
- R2: A write with upper byte 0xA5 loads bits 6:0 of the low byte into control/status, and bits 6, 4 and 3 are kept as written. The same write clears the prescaler, so no prescaler tick happens on that cycle.
- R3: A write with upper byte 0x5A loads the low byte into the counter on the next clock edge.
- R4: A write whose upper byte is neither 0xA5 nor 0x5A changes neither control/status nor the counter.
- R5: While control/status bit 5 (enable) is 0, the counter holds its value.
- R6: Control/status bits 2:0 pick the divide ratio. Select 0 gives 2, selects 1..5 give 64, 128, 256, 512 and 1024, and selects 6 and 7 give 4096 and 8192. After an 0xA5 write, the first increment lands on the clock edge that is the ratio-th enabled edge after the write.
- R7: The prescaler advances only on cycles where the clock enable input is high.
- R8: An increment from 0xFF yields 0x00, counting continues, and control/status bit 7 is set.
- R9: Bit 7 of control/status stays set until an 0xA5 write with bit 7 at 0 clears it. An 0xA5 write with bit 7 at 1 leaves it unchanged.
- R10: Each overflow produces a request pulse exactly one cycle long. With it, the level output shows bits 7:4 of the priority byte and the vector output shows bits 6:0 of the vector byte, as sampled on the overflow edge. Both values hold until the next overflow.
- R11: The read data shows control/status when the read select is 0 and the counter when it is 1.
- R12: A counter load on the same edge as a prescaler tick wins, and the tick is lost. Back-to-back 0xA5 writes keep the prescaler from ever ticking.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Peripheral clock enable that steps the prescaler |
| wr_en | input | 1 | Write strobe for the keyed port |
| wr_data | input | 16 | Key in bits 15:8, value in bits 7:0 |
| rd_sel | input | 1 | 0 reads control/status, 1 reads the counter |
| rd_data | output | 8 | Selected register value |
| prio_byte | input | 8 | Priority register byte; bits 7:4 give the level |
| vec_byte | input | 8 | Vector register byte; bits 6:0 give the vector |
| irq_pulse | output | 1 | One-cycle overflow request |
| irq_level | output | 4 | Level captured at the last overflow |
| irq_vector | output | 7 | Vector captured at the last overflow |

## Verification
The bench walks all eight clock selects and measures where the first increment lands. A design with an off-by-one shift would increment one ratio early or late, and one that treated selects 6 and 7 like the others would run twice as fast there. It forces the 0xFF wrap with a preloaded counter. It checks that the flag survives an 0xA5 write with bit 7 set, and that the level and vector stay fixed when the priority byte changes after the pulse. A design that let the request last two cycles, or that passed the priority byte straight through, would fail here. Collisions are covered too: counter loads on tick edges, repeated prescaler restarts, wrong keys and a gated clock enable. A design that let a tick beat a load, or that kept stepping the prescaler while the enable is low, would lose or gain counts.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W   = 8;
  localparam int LVL_W   = 4;
  localparam int VEC_W   = 7;
  localparam int SEL_W   = 3;
  localparam int EN_BIT  = 5;
  localparam int OVF_BIT = 7;
  localparam logic [7:0] KEY_CSR = 8'hA5;
  localparam logic [7:0] KEY_CNT = 8'h5A;

  // Log2 of the prescale ratio for a clock-select code.
  function automatic int div_shift(input logic [SEL_W-1:0] sel);
    if (sel == '0) return 1;
    else if (sel < 3'd6) return int'(sel) + 5;
    else return int'(sel) + 6;
  endfunction

  localparam int PRE_W = div_shift(3'd7);

  // Low-bit mask whose all-ones state marks the last count before a tick.
  function automatic logic [PRE_W-1:0] wrap_mask(input logic [SEL_W-1:0] sel);
    logic [PRE_W-1:0] m;
    m = '0;
    for (int i = 0; i < PRE_W; i++)
      if (i < div_shift(sel)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  assign mask = wrap_mask(sel);
  assign tick = clk_en & ~clr & ((pre & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre <= '0;
    else if (clr)    pre <= '0;
    else if (clk_en) pre <= pre + 1'b1;
  end

  // R2
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pre == '0);

  // R7
  pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !clr) |=> $stable(pre));
endmodule

// File: rtl/wdt_keyregs.sv
module wdt_keyregs
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  input  logic             ovf_evt,
  output logic [7:0]       csr,
  output logic             csr_wr,
  output logic             cnt_wr,
  output logic [CNT_W-1:0] load_val
);
  assign csr_wr   = wr_en && (wr_data[15:8] == KEY_CSR);
  assign cnt_wr   = wr_en && (wr_data[15:8] == KEY_CNT);
  assign load_val = wr_data[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csr <= '0;
    else if (csr_wr)
      csr <= {csr[OVF_BIT] & wr_data[OVF_BIT], wr_data[OVF_BIT-1:0]};
    else if (ovf_evt)
      csr[OVF_BIT] <= 1'b1;
  end

  // R4
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15:8] != 8'hA5 && !ovf_evt) |=> $stable(csr));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr[OVF_BIT] && !(wr_en && wr_data[15:8] == 8'hA5 && !wr_data[OVF_BIT]))
      |=> csr[OVF_BIT]);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [7:0]       prio_byte,
  input  logic [7:0]       vec_byte,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             irq_pulse,
  output logic [LVL_W-1:0] irq_level,
  output logic [VEC_W-1:0] irq_vector
);
  logic step;

  assign step    = tick & en & ~load;
  assign ovf_evt = step & (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      irq_pulse  <= 1'b0;
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq_pulse <= ovf_evt;
      if (load)      cnt <= load_val;
      else if (step) cnt <= cnt + 1'b1;
      if (ovf_evt) begin
        irq_level  <= prio_byte[7:8-LVL_W];
        irq_vector <= vec_byte[VEC_W-1:0];
      end
    end
  end

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt == '0) && irq_pulse);

  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> irq_level == $past(prio_byte[7:4]));

  // R5
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(cnt));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
endmodule

// File: rtl/wdog_interval_timer.sv
module wdog_interval_timer
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             wr_en,
  input  logic [15:0]      wr_data,
  input  logic             rd_sel,
  output logic [7:0]       rd_data,
  input  logic [7:0]       prio_byte,
  input  logic [7:0]       vec_byte,
  output logic             irq_pulse,
  output logic [LVL_W-1:0] irq_level,
  output logic [VEC_W-1:0] irq_vector
);
  logic [7:0]       csr;
  logic             csr_wr;
  logic             cnt_wr;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             ovf_evt;

  wdt_keyregs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ovf_evt(ovf_evt), .csr(csr), .csr_wr(csr_wr), .cnt_wr(cnt_wr),
    .load_val(load_val)
  );

  wdt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .clr(csr_wr),
    .sel(csr[SEL_W-1:0]), .tick(tick)
  );

  wdt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(csr[EN_BIT]),
    .load(cnt_wr), .load_val(load_val), .prio_byte(prio_byte),
    .vec_byte(vec_byte), .cnt(cnt), .ovf_evt(ovf_evt),
    .irq_pulse(irq_pulse), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  assign rd_data = rd_sel ? cnt : csr;

  // R2
  csr_tick_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr |-> !tick);
endmodule

// File: tb/wdog_interval_timer_test.sv
module wdog_interval_timer_test;
  logic clk = 0, rst_n = 0, clk_en = 1, wr_en = 0, rd_sel = 0;
  logic [15:0] wr_data = 0;
  logic [7:0] prio_byte = 0, vec_byte = 0;
  logic [7:0] rd_data;
  logic irq_pulse;
  logic [3:0] irq_level;
  logic [6:0] irq_vector;

  wdog_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .prio_byte(prio_byte), .vec_byte(vec_byte), .irq_pulse(irq_pulse),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string ph = "R1";
  bit done = 0;

  int m_pre = 0, m_cnt = 0, m_csr = 0, m_irq = 0, m_lvl = 0, m_vec = 0;
  int t_csrw, t_cntw, t_tick, t_ovf, t_div, t_en;

  function automatic int divof(input int s);
    case (s)
      0: return 2;    1: return 64;   2: return 128;  3: return 256;
      4: return 512;  5: return 1024; 6: return 4096; default: return 8192;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural reference model, updated on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_csr = 0; m_irq = 0; m_lvl = 0; m_vec = 0;
    end else begin
      t_csrw = (wr_en && wr_data[15:8] == 8'hA5) ? 1 : 0;
      t_cntw = (wr_en && wr_data[15:8] == 8'h5A) ? 1 : 0;
      t_div  = divof(m_csr % 8);
      t_en   = (m_csr / 32) % 2;
      t_tick = (clk_en && !t_csrw && (m_pre % t_div) == t_div - 1) ? 1 : 0;
      t_ovf  = 0;
      m_irq  = 0;
      if (t_csrw) m_pre = 0;
      else if (clk_en) m_pre = (m_pre + 1) % 8192;
      if (t_cntw) m_cnt = int'(wr_data[7:0]);
      else if (t_tick && t_en) begin
        if (m_cnt == 255) begin
          m_cnt = 0; t_ovf = 1; m_irq = 1;
          m_lvl = int'(prio_byte) / 16;
          m_vec = int'(vec_byte) % 128;
        end else m_cnt = m_cnt + 1;
      end
      if (t_csrw)
        m_csr = ((m_csr >= 128 && wr_data[7]) ? 128 : 0) + int'(wr_data[6:0]);
      else if (t_ovf && m_csr < 128)
        m_csr = m_csr + 128;
    end
  end

  // Compare against the model on every clock, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(int'(rd_data) == (rd_sel ? m_cnt : m_csr), ph, rd_data, rd_sel ? m_cnt : m_csr);
      chk(int'(irq_pulse) == m_irq, ph, irq_pulse, m_irq);
      chk(int'(irq_level) == m_lvl, ph, irq_level, m_lvl);
      chk(int'(irq_vector) == m_vec, ph, irq_vector, m_vec);
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic wr(input logic [7:0] k, input logic [7:0] v);
    wr_en = 1; wr_data = {k, v};
    cyc();
    wr_en = 0;
  endtask

  task automatic rd(input logic s, output int v);
    rd_sel = s; #1; v = int'(rd_data);
  endtask

  initial begin
    #(150000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    ph = "R1";
    rd(0, v); chk(v == 0, "R1", v, 0);
    rd(1, v); chk(v == 0, "R1", v, 0);
    chk(irq_pulse == 0, "R1", irq_pulse, 0);

    // R3 counter load
    ph = "R3";
    wr(8'h5A, 8'h10);
    rd(1, v); chk(v == 8'h10, "R3", v, 8'h10);

    // R4 wrong keys
    ph = "R4";
    wr(8'h33, 8'h77);
    wr(8'hA4, 8'h3F);
    wr(8'h5B, 8'h99);
    rd(1, v); chk(v == 8'h10, "R4", v, 8'h10);
    rd(0, v); chk(v == 0, "R4", v, 0);

    // R5 disabled counter holds
    ph = "R5";
    wr(8'hA5, 8'h00);
    rd_sel = 1;
    repeat (20) cyc();
    rd(1, v); chk(v == 8'h10, "R5", v, 8'h10);

    // R6 every clock select
    ph = "R6";
    for (int s = 0; s < 8; s++) begin
      wr(8'h5A, 8'h00);
      wr(8'hA5, 8'(8'h20 | s));
      rd_sel = 1;
      repeat (divof(s) - 1) cyc();
      rd(1, v); chk(v == 0, "R6", v, 0);
      cyc();
      rd(1, v); chk(v == 1, "R6", v, 1);
    end

    // R8 / R10 wrap and request
    ph = "R8";
    prio_byte = 8'hB7; vec_byte = 8'hC5;
    wr(8'h5A, 8'hFE);
    wr(8'hA5, 8'h20);
    rd_sel = 1;
    repeat (3) cyc();
    rd(1, v); chk(v == 8'hFF, "R8", v, 8'hFF);
    chk(irq_pulse == 0, "R10", irq_pulse, 0);
    cyc();
    ph = "R10";
    chk(irq_pulse == 1, "R10", irq_pulse, 1);
    chk(irq_level == 4'hB, "R10", irq_level, 4'hB);
    chk(irq_vector == 7'h45, "R10", irq_vector, 7'h45);
    rd(1, v); chk(v == 0, "R8", v, 0);
    rd(0, v); chk(v == 8'hA0, "R8", v, 8'hA0);
    prio_byte = 8'h30; vec_byte = 8'h11;
    cyc();
    chk(irq_pulse == 0, "R10", irq_pulse, 0);
    chk(irq_level == 4'hB, "R10", irq_level, 4'hB);
    chk(irq_vector == 7'h45, "R10", irq_vector, 7'h45);

    // R9 sticky flag
    ph = "R9";
    wr(8'hA5, 8'h80);
    rd(0, v); chk(v == 8'h80, "R9", v, 8'h80);
    wr(8'hA5, 8'h00);
    rd(0, v); chk(v == 8'h00, "R9", v, 8'h00);

    // R2 stored bits
    ph = "R2";
    wr(8'hA5, 8'h5B);
    rd(0, v); chk(v == 8'h5B, "R2", v, 8'h5B);
    wr(8'hA5, 8'h00);

    // R7 clock enable gating
    ph = "R7";
    clk_en = 0;
    wr(8'hA5, 8'h20);
    wr(8'h5A, 8'h05);
    repeat (10) cyc();
    rd(1, v); chk(v == 5, "R7", v, 5);
    clk_en = 1;
    cyc(); cyc();
    clk_en = 0;
    repeat (5) cyc();
    rd(1, v); chk(v == 6, "R7", v, 6);
    for (int i = 0; i < 60; i++) begin
      clk_en = (i % 3 == 0);
      cyc();
    end
    clk_en = 1;

    // R12 collisions
    ph = "R12";
    wr(8'hA5, 8'h20);
    for (int i = 0; i < 4; i++) wr(8'h5A, 8'h40);
    rd(1, v); chk(v == 8'h40, "R12", v, 8'h40);
    for (int i = 0; i < 6; i++) wr(8'hA5, 8'h20);
    rd(1, v); chk(v == 8'h40, "R12", v, 8'h40);
    cyc(); cyc();
    rd(1, v); chk(v == 8'h41, "R12", v, 8'h41);

    // R11 read select
    ph = "R11";
    for (int i = 0; i < 10; i++) begin
      rd_sel = i[0];
      cyc();
    end
    wr(8'h5A, 8'h3C);
    wr(8'hA5, 8'h01);
    rd(0, v); chk(v == 8'h01, "R11", v, 8'h01);
    rd(1, v); chk(v == 8'h3C, "R11", v, 8'h3C);
    cyc();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule